// File: doc/BRIEF.md
# Accumulator Subtract and Test Flag Unit

This combinational unit is the subtract-and-test slice of an 8-bit ALU. It takes the accumulator value, a second operand and an operation select. It returns a result byte, a write strobe for the accumulator and six condition flags: sign, zero, half, parity/overflow, add-subtract and carry. Operand fetch, the other ALU operations and the flag register itself sit outside the unit.

In subtract mode the unit forms the accumulator minus the operand, with no borrow coming in. The difference goes back to the accumulator. The flags then report the nibble borrow, signed overflow and the borrow out of the top bit.

In test mode the unit forms the bitwise AND of the two inputs. It presents that value and the flags it produces, but it never asserts the accumulator write strobe. In this mode the parity/overflow flag carries even parity, and the half flag is forced high.

Top module: `acc_subtst_unit`

## Requirements
- R1: With op_test_i = 0 (subtract), res_o equals (acc_i - opnd_i) modulo 256 and acc_we_o is 1.
- R2: With op_test_i = 0, flag_s_o equals res_o bit 7, and flag_z_o is 1 exactly when res_o is 0.
- R3: With op_test_i = 0, flag_h_o is 1 exactly when the value of acc_i bits 3..0 is smaller than the value of opnd_i bits 3..0.
- R4: With op_test_i = 0, flag_pv_o is 1 exactly when the signed (two's-complement) difference lies outside -128..127.
- R5: With op_test_i = 0, flag_n_o is 1, and flag_c_o is 1 exactly when acc_i is smaller than opnd_i taken as unsigned values.
- R6: With op_test_i = 1 (test), res_o equals acc_i AND opnd_i and acc_we_o is 0.
- R7: With op_test_i = 1, flag_s_o equals bit 7 of the AND value, and flag_z_o is 1 exactly when that value is 0.
- R8: With op_test_i = 1, flag_h_o is 1, flag_n_o is 0 and flag_c_o is 0.
- R9: With op_test_i = 1, flag_pv_o is 1 exactly when the AND value has an even number of 1 bits. Zero 1 bits counts as even.
- R10: Subtracting equal operands gives res_o = 0 with flag_z_o = 1, flag_c_o = 0, flag_h_o = 0, flag_pv_o = 0 and flag_n_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| op_test_i | input | 1 | 0 selects subtract, 1 selects test |
| res_o | output | 8 | Difference (subtract) or AND value (test) |
| acc_we_o | output | 1 | Accumulator write strobe, high for subtract only |
| flag_s_o | output | 1 | Sign flag |
| flag_z_o | output | 1 | Zero flag |
| flag_h_o | output | 1 | Half flag: nibble borrow, or forced high for test |
| flag_pv_o | output | 1 | Signed overflow (subtract) or even parity (test) |
| flag_n_o | output | 1 | Add-subtract flag |
| flag_c_o | output | 1 | Carry flag: borrow (subtract) or 0 (test) |

## Verification
The bench drives all 65,536 pairs of accumulator and operand values through both operations and compares each against an integer model. In subtract mode this sweep separates nibble borrows from full borrows, and it hits every sign combination that can overflow. It also covers the diagonal of equal inputs, where zero must be set while carry, half and overflow stay clear. In test mode the same sweep shows parity in every AND weight, including the empty value, and confirms that the write strobe stays low.

// File: rtl/acc_subtst_pkg.sv
package acc_subtst_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = 4;

  typedef enum logic {
    OP_SUB  = 1'b0,
    OP_TEST = 1'b1
  } op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic h;
    logic pv;
    logic n;
    logic c;
  } flags_t;
endpackage

// File: rtl/acc_sub_path.sv
module acc_sub_path #(
  parameter int unsigned W   = 8,
  parameter int unsigned NIB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] diff_o,
  output logic         borrow_o,
  output logic         nib_borrow_o,
  output logic         ovf_o
);
  localparam int unsigned MSB = W - 1;

  logic [W:0]   wide_diff;
  logic [NIB:0] low_diff;

  always_comb begin
    wide_diff    = {1'b0, a_i} - {1'b0, b_i};
    low_diff     = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]};
    diff_o       = wide_diff[W-1:0];
    borrow_o     = wide_diff[W];
    nib_borrow_o = low_diff[NIB];
    ovf_o        = (a_i[MSB] ^ b_i[MSB]) & (wide_diff[MSB] ^ a_i[MSB]);
  end
endmodule

// File: rtl/acc_test_path.sv
module acc_test_path #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic         even_o
);
  logic [W:0] par_chain;

  assign and_o        = a_i & b_i;
  assign par_chain[0] = 1'b0;

  generate
    for (genvar gi = 0; gi < W; gi++) begin : g_par
      assign par_chain[gi+1] = par_chain[gi] ^ and_o[gi];
    end
  endgenerate

  assign even_o = ~par_chain[W];
endmodule

// File: rtl/acc_flag_sel.sv
module acc_flag_sel
  import acc_subtst_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] diff_i,
  input  logic         borrow_i,
  input  logic         nib_borrow_i,
  input  logic         ovf_i,
  input  logic [W-1:0] and_i,
  input  logic         even_i,
  output logic [W-1:0] res_o,
  output logic         we_o,
  output flags_t       flags_o
);
  always_comb begin
    res_o   = diff_i;
    we_o    = 1'b1;
    flags_o = '0;
    unique case (op_i)
      OP_SUB: begin
        res_o      = diff_i;
        we_o       = 1'b1;
        flags_o.h  = nib_borrow_i;
        flags_o.pv = ovf_i;
        flags_o.n  = 1'b1;
        flags_o.c  = borrow_i;
      end
      OP_TEST: begin
        res_o      = and_i;
        we_o       = 1'b0;
        flags_o.h  = 1'b1;
        flags_o.pv = even_i;
        flags_o.n  = 1'b0;
        flags_o.c  = 1'b0;
      end
      default: ;
    endcase
    flags_o.s = res_o[W-1];
    flags_o.z = (res_o == '0);
  end
endmodule

// File: rtl/acc_subtst_unit.sv
module acc_subtst_unit
  import acc_subtst_pkg::*;
(
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       op_test_i,
  output logic [7:0] res_o,
  output logic       acc_we_o,
  output logic       flag_s_o,
  output logic       flag_z_o,
  output logic       flag_h_o,
  output logic       flag_pv_o,
  output logic       flag_n_o,
  output logic       flag_c_o
);
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] and_val;
  logic              borrow;
  logic              nib_borrow;
  logic              ovf;
  logic              even;
  op_e               op;
  flags_t            flags;

  assign op = op_e'(op_test_i);

  acc_sub_path #(.W(DATA_W), .NIB(NIB_W)) u_sub (
    .a_i          (acc_i),
    .b_i          (opnd_i),
    .diff_o       (diff),
    .borrow_o     (borrow),
    .nib_borrow_o (nib_borrow),
    .ovf_o        (ovf)
  );

  acc_test_path #(.W(DATA_W)) u_tst (
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .and_o  (and_val),
    .even_o (even)
  );

  acc_flag_sel #(.W(DATA_W)) u_sel (
    .op_i         (op),
    .diff_i       (diff),
    .borrow_i     (borrow),
    .nib_borrow_i (nib_borrow),
    .ovf_i        (ovf),
    .and_i        (and_val),
    .even_i       (even),
    .res_o        (res_o),
    .we_o         (acc_we_o),
    .flags_o      (flags)
  );

  assign flag_s_o  = flags.s;
  assign flag_z_o  = flags.z;
  assign flag_h_o  = flags.h;
  assign flag_pv_o = flags.pv;
  assign flag_n_o  = flags.n;
  assign flag_c_o  = flags.c;
endmodule

// File: rtl/acc_subtst_chk.sv
module acc_subtst_chk (
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic       op_test_i,
  input logic [7:0] res_o,
  input logic       acc_we_o,
  input logic       flag_s_o,
  input logic       flag_z_o,
  input logic       flag_h_o,
  input logic       flag_pv_o,
  input logic       flag_n_o,
  input logic       flag_c_o
);
  logic [7:0] back_sum;
  assign back_sum = res_o + opnd_i;

  always_comb begin
    if (!op_test_i) begin
      a_r1_sub_inverse: assert (back_sum == acc_i && acc_we_o);
      a_r3_nibble_borrow: assert (flag_h_o == (acc_i[3:0] < opnd_i[3:0]));
      a_r5_borrow_out: assert (flag_n_o && (flag_c_o == (acc_i < opnd_i)));
      a_r10_self_sub: assert (acc_i != opnd_i ||
        (flag_z_o && !flag_c_o && !flag_h_o && !flag_pv_o));
    end else begin
      a_r6_test_no_write: assert (!acc_we_o && res_o == (acc_i & opnd_i));
      a_r8_test_fixed: assert (flag_h_o && !flag_n_o && !flag_c_o);
      a_r9_test_parity: assert (flag_pv_o == ($countones(res_o) % 2 == 0));
    end
    a_r2_r7_zero_sign: assert (flag_z_o == (res_o == 8'd0) && flag_s_o == res_o[7]);
  end
endmodule

bind acc_subtst_unit acc_subtst_chk u_chk (
  .acc_i     (acc_i),
  .opnd_i    (opnd_i),
  .op_test_i (op_test_i),
  .res_o     (res_o),
  .acc_we_o  (acc_we_o),
  .flag_s_o  (flag_s_o),
  .flag_z_o  (flag_z_o),
  .flag_h_o  (flag_h_o),
  .flag_pv_o (flag_pv_o),
  .flag_n_o  (flag_n_o),
  .flag_c_o  (flag_c_o)
);

// File: tb/acc_subtst_unit_tb.sv
module acc_subtst_unit_tb;
  logic       clk;
  logic       rst_n;
  logic [7:0] acc_i;
  logic [7:0] opnd_i;
  logic       op_test_i;
  logic [7:0] res_o;
  logic       acc_we_o;
  logic       flag_s_o, flag_z_o, flag_h_o, flag_pv_o, flag_n_o, flag_c_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  acc_subtst_unit u_dut (
    .acc_i     (acc_i),
    .opnd_i    (opnd_i),
    .op_test_i (op_test_i),
    .res_o     (res_o),
    .acc_we_o  (acc_we_o),
    .flag_s_o  (flag_s_o),
    .flag_z_o  (flag_z_o),
    .flag_h_o  (flag_h_o),
    .flag_pv_o (flag_pv_o),
    .flag_n_o  (flag_n_o),
    .flag_c_o  (flag_c_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles %0d expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ref_compare(input int a, input int b, input bit tst);
    int r, sa, sb, sd, ones;
    if (!tst) begin
      r  = a - b;
      sa = (a > 127) ? a - 256 : a;
      sb = (b > 127) ? b - 256 : b;
      sd = sa - sb;
      check("R1 result", int'(res_o), (r + 256) % 256);
      check("R1 write", int'(acc_we_o), 1);
      check("R2 sign", int'(flag_s_o), (((r + 256) % 256) >= 128) ? 1 : 0);
      check("R2 zero", int'(flag_z_o), (r == 0) ? 1 : 0);
      check("R3 half", int'(flag_h_o), ((a % 16) < (b % 16)) ? 1 : 0);
      check("R4 overflow", int'(flag_pv_o), (sd < -128 || sd > 127) ? 1 : 0);
      check("R5 nflag", int'(flag_n_o), 1);
      check("R5 carry", int'(flag_c_o), (a < b) ? 1 : 0);
      if (a == b)
        check("R10 self", int'({res_o, flag_z_o, flag_c_o, flag_h_o, flag_pv_o, flag_n_o}),
              int'({8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}));
    end else begin
      r = 0;
      ones = 0;
      for (int k = 0; k < 8; k++) begin
        if (((a >> k) & 1) == 1 && ((b >> k) & 1) == 1) begin
          r = r + (1 << k);
          ones = ones + 1;
        end
      end
      check("R6 and", int'(res_o), r);
      check("R6 nowrite", int'(acc_we_o), 0);
      check("R7 sign", int'(flag_s_o), (r >= 128) ? 1 : 0);
      check("R7 zero", int'(flag_z_o), (r == 0) ? 1 : 0);
      check("R8 fixed", int'({flag_h_o, flag_n_o, flag_c_o}), 4);
      check("R9 parity", int'(flag_pv_o), (ones % 2 == 0) ? 1 : 0);
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    acc_i     = 8'd0;
    opnd_i    = 8'd0;
    op_test_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state: subtract of zero from zero
    check("R10 idle", int'({res_o, acc_we_o, flag_z_o}), int'({8'd0, 1'b1, 1'b1}));
    for (int op = 0; op < 2; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          @(posedge clk);
          acc_i     = 8'(a);
          opnd_i    = 8'(b);
          op_test_i = op[0];
          @(negedge clk);
          if (rst_n) ref_compare(a, b, op[0]);
        end
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule